// File: doc/BRIEF.md
# I2C Controller Event Status Register

This block keeps the sticky event flags of an I2C controller and presents them to software as one status word. The bus engine sends it single-cycle pulses for six events: a START or STOP seen at an illegal point in a transfer (bus error), a not-acknowledge returned by the receiver, loss of arbitration, being addressed by a general call, completion of the address phase, and a STOP condition seen while acting as a slave. Each pulse sets its own flag, and the flag stays set until software clears it.

Two clearing rules share the status word. The three fault flags (bus error, NACK, arbitration lost) are cleared only by writing one to their bit. The three progress flags (general call, address done, STOP) clear themselves when the status word is read. A second register holds one interrupt enable per flag, and the interrupt output is the OR of every enabled flag. The block also drives three control outputs back to the engine: a request to release SDA and SCL after a bus error in master mode, a hold on new transfers while arbitration loss is pending, and a hold on the next address byte while a bus error is pending.

Top module: `i2c_evt_status`

## Requirements
- R1: A read of address 0 returns the flags at fixed bit positions: bus error bit 10, NACK bit 9, arbitration lost bit 8, general call bit 3, address done bit 2, STOP bit 1. Read data is combinational while `reg_rd` is high and is 0 when `reg_rd` is low.
- R2: An event pulse sets its flag at the next clock edge, and the flag stays set with no further pulse until cleared as R3 or R4 describe.
- R3: Bus error, NACK and arbitration lost clear only when a write to address 0 carries a 1 at their bit position; a 0 in that position, or a read, leaves them unchanged.
- R4: General call, address done and STOP clear at the clock edge that ends a read of address 0; writes to address 0 leave them unchanged.
- R5: When an event pulse and a write-one clear hit the same flag in the same cycle, the flag is set afterwards.
- R6: When an event pulse for a clear-on-read flag arrives in the same cycle as a read of address 0, the read returns the older value and the flag is set afterwards.
- R7: The STOP pulse sets its flag only while `is_master` is 0.
- R8: `release_lines` is high exactly while the bus error flag is set and `is_master` is 1.
- R9: `xfer_block` is high while the arbitration lost flag is set; `addr_block` is high while the bus error flag is set.
- R10: Address 1 holds an interrupt enable for each flag at the same bit position as the flag; `irq` is high when any flag is set together with its enable.
- R11: Bits other than 10, 9, 8, 3, 2, 1 read as 0 at both addresses, and writing them has no effect.
- R12: After reset all flags and all enables are 0, and `irq`, `release_lines`, `xfer_block` and `addr_block` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| is_master | input | 1 | 1 while the controller acts as bus master |
| ev_bus_err | input | 1 | Pulse: START/STOP at an illegal point |
| ev_nack | input | 1 | Pulse: not-acknowledge received |
| ev_arb_lost | input | 1 | Pulse: bus ownership lost |
| ev_gen_call | input | 1 | Pulse: addressed by a general call |
| ev_addr_done | input | 1 | Pulse: address phase finished |
| ev_stop | input | 1 | Pulse: STOP condition seen |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 1 | 0 = status word, 1 = interrupt enables |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data |
| irq | output | 1 | Interrupt request |
| release_lines | output | 1 | Request to release SDA and SCL |
| xfer_block | output | 1 | Blocks the start of a new transfer |
| addr_block | output | 1 | Blocks sending or accepting the next address byte |

## Verification
A flag stuck at the wrong value shows at the status read one cycle after the pulse or clear that should have moved it, and at once on `irq` and on whichever control output it feeds. A wrong clearing rule appears on the very next read: a fault flag that vanishes after a read, or a progress flag that survives one. The race cases (set against clear, event against read) show as a missing bit on the read that follows the collision, so each is checked with a second read right after it.

// File: rtl/i2c_evt_pkg.sv
// Shared constants for the I2C event status register.
// Assumes six flags; index order is fixed and used by all modules.
package i2c_evt_pkg;
    localparam int REG_W  = 16;
    localparam int NFLAG  = 6;
    localparam int POS_W  = $clog2(REG_W);

    // Flag indices
    localparam int F_BUSERR = 0;
    localparam int F_NACK   = 1;
    localparam int F_ARB    = 2;
    localparam int F_GCALL  = 3;
    localparam int F_ADDR   = 4;
    localparam int F_STOP   = 5;

    // Bit position of each flag in the register word
    localparam int FLAG_POS [NFLAG] = '{10, 9, 8, 3, 2, 1};

    typedef enum logic {CLR_W1C = 1'b0, CLR_ON_READ = 1'b1} clr_mode_e;

    // Clearing rule of each flag
    function automatic clr_mode_e flag_mode(input int idx);
        return (idx <= F_ARB) ? CLR_W1C : CLR_ON_READ;
    endfunction

    // Spread a flag vector onto register bit positions
    function automatic logic [REG_W-1:0] to_word(input logic [NFLAG-1:0] f);
        logic [REG_W-1:0] w;
        w = '0;
        for (int i = 0; i < NFLAG; i++) w[FLAG_POS[i]] = f[i];
        return w;
    endfunction

    // Gather a flag vector from register bit positions
    function automatic logic [NFLAG-1:0] from_word(input logic [REG_W-1:0] w);
        logic [NFLAG-1:0] f;
        for (int i = 0; i < NFLAG; i++) f[i] = w[FLAG_POS[i]];
        return f;
    endfunction

    // Mask of implemented bit positions
    function automatic logic [REG_W-1:0] used_mask();
        return to_word({NFLAG{1'b1}});
    endfunction
endpackage

// File: rtl/i2c_evt_flag.sv
// One sticky event flag. Set by a hardware pulse, cleared by the
// request selected by MODE. Assumes a set has priority over a clear.
module i2c_evt_flag
    import i2c_evt_pkg::*;
#(
    parameter clr_mode_e MODE = CLR_W1C
) (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic w1c_i,
    input  logic rd_clr_i,
    output logic flag_o
);
    logic clr;

    // Pick the clear source that this flag obeys
    generate
        if (MODE == CLR_W1C) begin : g_w1c
            assign clr = w1c_i;
        end else begin : g_cor
            assign clr = rd_clr_i;
        end
    endgenerate

    // Hold the flag; set wins over clear in the same cycle
    always_ff @(posedge clk) begin
        if (!rst_n)      flag_o <= 1'b0;
        else if (set_i)  flag_o <= 1'b1;
        else if (clr)    flag_o <= 1'b0;
    end
endmodule

// File: rtl/i2c_evt_ien.sv
// Interrupt enable register: one bit per flag, written at the
// flag's own bit position. Unused bit positions are not stored.
module i2c_evt_ien
    import i2c_evt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we_i,
    input  logic [REG_W-1:0] wdata_i,
    output logic [NFLAG-1:0] en_o
);
    // Store enables from the mapped bit positions
    always_ff @(posedge clk) begin
        if (!rst_n)    en_o <= '0;
        else if (we_i) en_o <= from_word(wdata_i);
    end
endmodule

// File: rtl/i2c_evt_rdmux.sv
// Read data select. Returns 0 when no read is in progress and
// only implemented bit positions otherwise.
module i2c_evt_rdmux
    import i2c_evt_pkg::*;
(
    input  logic             rd_i,
    input  logic             addr_i,
    input  logic [NFLAG-1:0] flags_i,
    input  logic [NFLAG-1:0] en_i,
    output logic [REG_W-1:0] rdata_o
);
    // Select the addressed register and spread it onto the word
    always_comb begin
        rdata_o = '0;
        if (rd_i) rdata_o = to_word(addr_i ? en_i : flags_i);
    end
endmodule

// File: rtl/i2c_evt_status.sv
// I2C controller event status register top. Latches six event
// pulses into sticky flags with mixed clearing rules, provides an
// enable register, an interrupt and bus-engine control outputs.
// Assumes event inputs are single-cycle pulses synchronous to clk.
module i2c_evt_status
    import i2c_evt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             is_master,
    input  logic             ev_bus_err,
    input  logic             ev_nack,
    input  logic             ev_arb_lost,
    input  logic             ev_gen_call,
    input  logic             ev_addr_done,
    input  logic             ev_stop,
    input  logic             reg_wr,
    input  logic             reg_rd,
    input  logic             reg_addr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    output logic             irq,
    output logic             release_lines,
    output logic             xfer_block,
    output logic             addr_block
);
    logic [NFLAG-1:0] ev_set;
    logic [NFLAG-1:0] w1c_hit;
    logic [NFLAG-1:0] flag_q;
    logic [NFLAG-1:0] en_q;
    logic             stat_rd;
    logic             stat_wr;

    // Gather event pulses; STOP counts only in slave mode
    always_comb begin
        ev_set           = '0;
        ev_set[F_BUSERR] = ev_bus_err;
        ev_set[F_NACK]   = ev_nack;
        ev_set[F_ARB]    = ev_arb_lost;
        ev_set[F_GCALL]  = ev_gen_call;
        ev_set[F_ADDR]   = ev_addr_done;
        ev_set[F_STOP]   = ev_stop & ~is_master;
    end

    // Decode status-word accesses
    assign stat_rd = reg_rd & ~reg_addr;
    assign stat_wr = reg_wr & ~reg_addr;
    assign w1c_hit = stat_wr ? from_word(reg_wdata) : '0;

    generate
        for (genvar i = 0; i < NFLAG; i++) begin : g_flag
            i2c_evt_flag #(.MODE(flag_mode(i))) u_flag (
                .clk      (clk),
                .rst_n    (rst_n),
                .set_i    (ev_set[i]),
                .w1c_i    (w1c_hit[i]),
                .rd_clr_i (stat_rd),
                .flag_o   (flag_q[i])
            );
        end
    endgenerate

    i2c_evt_ien u_ien (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (reg_wr & reg_addr),
        .wdata_i (reg_wdata),
        .en_o    (en_q)
    );

    i2c_evt_rdmux u_rdmux (
        .rd_i    (reg_rd),
        .addr_i  (reg_addr),
        .flags_i (flag_q),
        .en_i    (en_q),
        .rdata_o (reg_rdata)
    );

    // Interrupt and control outputs from the held flags
    assign irq           = |(flag_q & en_q);
    assign release_lines = flag_q[F_BUSERR] & is_master;
    assign xfer_block    = flag_q[F_ARB];
    assign addr_block    = flag_q[F_BUSERR];
endmodule

// File: rtl/i2c_evt_status_chk.sv
// Property checker for i2c_evt_status, attached by bind.
module i2c_evt_status_chk
    import i2c_evt_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             is_master,
    input logic             ev_bus_err,
    input logic             ev_nack,
    input logic             ev_stop,
    input logic             reg_wr,
    input logic             reg_rd,
    input logic             reg_addr,
    input logic [REG_W-1:0] reg_wdata,
    input logic [REG_W-1:0] reg_rdata,
    input logic             irq,
    input logic             release_lines,
    input logic             addr_block,
    input logic [NFLAG-1:0] flag_q
);
    // R2, R5: a pulse always leaves its flag set
    p_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ev_bus_err |=> flag_q[F_BUSERR]);
    p_set_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ev_nack |=> flag_q[F_NACK]);
    // R3: a fault flag falls only after a write-one to its bit
    p_w1c_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag_q[F_BUSERR]) |-> $past(reg_wr && !reg_addr && reg_wdata[FLAG_POS[F_BUSERR]]));
    // R4: a progress flag falls only after a status read
    p_cor_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag_q[F_ADDR]) |-> $past(reg_rd && !reg_addr));
    // R7: STOP flag rises only in slave mode
    p_stop_slave_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q[F_STOP]) |-> $past(!is_master && ev_stop));
    // R8, R9: release request implies the address hold
    p_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        release_lines |-> addr_block);
    // R10: interrupt needs at least one flag
    p_irq_r10: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ($countones(flag_q) > 0));
    // R11: unused bits never read as 1
    p_unused_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata & ~used_mask()) == '0);
endmodule

bind i2c_evt_status i2c_evt_status_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .is_master     (is_master),
    .ev_bus_err    (ev_bus_err),
    .ev_nack       (ev_nack),
    .ev_stop       (ev_stop),
    .reg_wr        (reg_wr),
    .reg_rd        (reg_rd),
    .reg_addr      (reg_addr),
    .reg_wdata     (reg_wdata),
    .reg_rdata     (reg_rdata),
    .irq           (irq),
    .release_lines (release_lines),
    .addr_block    (addr_block),
    .flag_q        (flag_q)
);

// File: tb/i2c_evt_status_test.sv
// Directed bench for i2c_evt_status. Inputs change at the falling
// edge; results are sampled 1 ns after the rising edge.
module i2c_evt_status_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        is_master = 1'b0;
    logic [5:0]  ev = '0;   // {stop, addr, gcall, arb, nack, buserr}
    logic        reg_wr = 1'b0, reg_rd = 1'b0, reg_addr = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        irq, release_lines, xfer_block, addr_block;
    int          n_chk = 0, n_bad = 0;

    localparam logic [5:0] E_BERR = 6'b000001, E_NACK = 6'b000010, E_ARB = 6'b000100,
                           E_GC = 6'b001000, E_AD = 6'b010000, E_STOP = 6'b100000;

    always #5 clk = ~clk;

    i2c_evt_status uut (
        .clk(clk), .rst_n(rst_n), .is_master(is_master),
        .ev_bus_err(ev[0]), .ev_nack(ev[1]), .ev_arb_lost(ev[2]),
        .ev_gen_call(ev[3]), .ev_addr_done(ev[4]), .ev_stop(ev[5]),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
        .release_lines(release_lines), .xfer_block(xfer_block),
        .addr_block(addr_block)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
        end
    endtask

    // One cycle of stimulus; rd_val is read data seen during the cycle
    task automatic cyc(input logic [5:0] e, input logic wr, input logic rd,
                       input logic a, input logic [15:0] wd, output logic [15:0] rd_val);
        @(negedge clk);
        ev = e; reg_wr = wr; reg_rd = rd; reg_addr = a; reg_wdata = wd;
        #1 rd_val = reg_rdata;
        @(posedge clk);
        #1 ev = '0; reg_wr = 1'b0; reg_rd = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd_reg(input logic a, output logic [15:0] v);
        cyc('0, 1'b0, 1'b1, a, '0, v);
    endtask

    task automatic wr_reg(input logic a, input logic [15:0] d);
        logic [15:0] dummy;
        cyc('0, 1'b1, 1'b0, a, d, dummy);
    endtask

    task automatic pulse(input logic [5:0] e);
        logic [15:0] dummy;
        cyc(e, 1'b0, 1'b0, 1'b0, '0, dummy);
    endtask

    task automatic t_reset;
        logic [15:0] v;
        check("R12 irq", {15'b0, irq}, 16'h0);
        check("R12 ctl", {13'b0, release_lines, xfer_block, addr_block}, 16'h0);
        check("R1 idle rdata", reg_rdata, 16'h0);
        rd_reg(1'b0, v); check("R12 status", v, 16'h0);
        rd_reg(1'b1, v); check("R12 enables", v, 16'h0);
    endtask

    task automatic t_layout;
        logic [15:0] v;
        is_master = 1'b0;
        pulse(E_BERR | E_NACK | E_ARB | E_GC | E_AD | E_STOP);
        pulse('0);
        rd_reg(1'b0, v); check("R1 R2 all flags", v, 16'h070E);
        rd_reg(1'b0, v); check("R4 cleared by read", v, 16'h0700);
    endtask

    task automatic t_w1c;
        logic [15:0] v;
        wr_reg(1'b0, 16'h0000);
        rd_reg(1'b0, v); check("R3 write 0 keeps", v, 16'h0700);
        wr_reg(1'b0, 16'h0200);
        rd_reg(1'b0, v); check("R3 clear NACK only", v, 16'h0500);
        wr_reg(1'b0, 16'h0500);
        rd_reg(1'b0, v); check("R3 clear rest", v, 16'h0000);
    endtask

    task automatic t_cor_write;
        logic [15:0] v;
        pulse(E_GC);
        wr_reg(1'b0, 16'h000E);
        rd_reg(1'b0, v); check("R4 write ignored", v, 16'h0008);
        rd_reg(1'b0, v); check("R4 gone after read", v, 16'h0000);
    endtask

    task automatic t_set_wins;
        logic [15:0] v;
        pulse(E_NACK);
        cyc(E_NACK, 1'b1, 1'b0, 1'b0, 16'h0200, v);
        rd_reg(1'b0, v); check("R5 set beats clear", v, 16'h0200);
        wr_reg(1'b0, 16'h0200);
        rd_reg(1'b0, v); check("R3 NACK cleared", v, 16'h0000);
    endtask

    task automatic t_read_race;
        logic [15:0] v;
        cyc(E_AD, 1'b0, 1'b1, 1'b0, '0, v);
        check("R6 read shows old", v, 16'h0000);
        rd_reg(1'b0, v); check("R6 event kept", v, 16'h0004);
        rd_reg(1'b0, v); check("R6 then cleared", v, 16'h0000);
    endtask

    task automatic t_stop_master;
        logic [15:0] v;
        is_master = 1'b1;
        pulse(E_STOP);
        rd_reg(1'b0, v); check("R7 STOP ignored as master", v, 16'h0000);
        is_master = 1'b0;
        pulse(E_STOP);
        rd_reg(1'b0, v); check("R7 STOP as slave", v, 16'h0002);
    endtask

    task automatic t_controls;
        logic [15:0] v;
        is_master = 1'b1;
        pulse(E_BERR);
        check("R8 release in master", {15'b0, release_lines}, 16'h1);
        check("R9 addr_block", {15'b0, addr_block}, 16'h1);
        rd_reg(1'b0, v);
        check("R3 read keeps bus error", {15'b0, addr_block}, 16'h1);
        is_master = 1'b0; #1;
        check("R8 no release in slave", {15'b0, release_lines}, 16'h0);
        wr_reg(1'b0, 16'h0400);
        check("R9 addr_block cleared", {15'b0, addr_block}, 16'h0);
        pulse(E_ARB);
        check("R9 xfer_block", {15'b0, xfer_block}, 16'h1);
        wr_reg(1'b0, 16'h0100);
        check("R9 xfer_block cleared", {15'b0, xfer_block}, 16'h0);
    endtask

    task automatic t_irq;
        logic [15:0] v;
        wr_reg(1'b1, 16'hFFFF);
        rd_reg(1'b1, v); check("R11 enable unused bits", v, 16'h070E);
        check("R10 no flags no irq", {15'b0, irq}, 16'h0);
        pulse(E_NACK);
        check("R10 irq raised", {15'b0, irq}, 16'h1);
        wr_reg(1'b1, 16'h0004);
        check("R10 masked", {15'b0, irq}, 16'h0);
        pulse(E_AD);
        check("R10 addr irq", {15'b0, irq}, 16'h1);
        rd_reg(1'b0, v); check("R1 status", v, 16'h0204);
        check("R10 irq drops", {15'b0, irq}, 16'h0);
        wr_reg(1'b0, 16'hF8F1);
        rd_reg(1'b0, v); check("R11 unused writes", v, 16'h0200);
        wr_reg(1'b0, 16'h0200);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_layout();
        t_w1c();
        t_cor_write();
        t_set_wins();
        t_read_race();
        t_stop_master();
        t_controls();
        t_irq();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule